// File: doc/BRIEF.md
# Multiplexed-Bus Expansion ROM Read Interface

This block reads bytes from an external ROM that shares a single 8-bit bidirectional bus for both address and data. A read request from the host side carries a byte address. The block sends that address as byte-wide slices. Each slice is captured by an external 8-bit holding register on its own one-cycle strobe. The block then releases the bus and asserts the ROM output enable. It waits a programmed number of cycles and captures the returned byte. A one-cycle done pulse marks that the byte is valid.

The ROM geometry is not fixed at build time. A few cycles after reset is released, the block keeps the bus tri-stated and samples the pull-up pattern on it once. That pattern gives the ROM size, from 16 KB to 1 MB in power-of-two steps, and the data-phase wait length. The size sets an offset mask, which goes to the base-address decode logic. The same mask clips request addresses, so accesses wrap inside the ROM.

The interface is intended for slow block transfers such as loading code, one read at a time.

Top module: `rom_bus_if`

## Requirements
- R1: While rst_ni is low: busy_o=1, cfg_valid_o=0, bus_oe_o=0, rom_oe_o=0, latch_o=0, done_o=0 and data_o=0.
- R2: After reset release the bus stays undriven (bus_oe_o=0, rom_oe_o=0). bus_i is sampled at the SENSE_CYC-th rising edge, and cfg_valid_o is 1 from that edge on. Changes on bus_i after that sample never alter the configuration.
- R3: The size code is sampled bus_i[2:0]; codes above ADDR_W-BASE_LOG2 (6 by default) are clamped. The ROM size is 2^(BASE_LOG2+code) bytes, and rom_mask_o equals size-1.
- R4: The sampled bus_i[4:3] value w sets the data phase to 2^w cycles (1, 2, 4 or 8).
- R5: A read sends address slices in order. latch_o=3'b001 with bus_o=addr[7:0] comes first, then latch_o=3'b010 with bus_o=addr[15:8]. A third step, latch_o=3'b100 with bus_o={4'b0,addr[19:16]}, follows only when the size exceeds 64 KB. Each step lasts one cycle with bus_oe_o=1.
- R6: The data phase directly follows the last strobe: bus_oe_o=0 and rom_oe_o=1 for the programmed cycle count. bus_i is captured at the final edge of that phase, and done_o is high for exactly the next cycle, with that byte on data_o.
- R7: Address bits at or above log2(size) are ignored: a read of addr returns the ROM byte at addr & rom_mask_o.
- R8: req_i is accepted only when busy_o=0, where busy_o = !cfg_valid_o or a read in progress. A request made at any other time has no effect.
- R9: data_o holds the last captured byte until the next done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken when busy_o is 0 |
| addr_i | input | ADDR_W | Byte address of the read |
| busy_o | output | 1 | Not configured yet, or read in progress |
| done_o | output | 1 | One-cycle pulse, data_o valid |
| data_o | output | 8 | Last byte read |
| bus_i | input | 8 | Shared bus input (pull-ups at sense, ROM data later) |
| bus_o | output | 8 | Address slice driven on the shared bus |
| bus_oe_o | output | 1 | Bus driver enable |
| latch_o | output | (ADDR_W+7)/8 | One strobe per external address holding register |
| rom_oe_o | output | 1 | ROM output enable |
| cfg_valid_o | output | 1 | Size and speed have been sensed |
| rom_mask_o | output | ADDR_W | Offset mask, ROM size minus one |

## Verification
A wrong sensed size shows at once on rom_mask_o. It also shows in the strobe count of the next read and in its data, where a wrong wrap point returns a wrong byte. A wrong wait count shifts done_o by cycles relative to rom_oe_o, which makes it visible within eight cycles of the first data phase. A sequencer that loses its slice index, or that accepts a request while busy, drives a wrong strobe or bus byte within the same read. The bench compares every cycle against a behavioural model, so such a fault is reported in the first cycle it reaches the pins.

// File: rtl/rom_bus_pkg.sv
package rom_bus_pkg;
  localparam int unsigned SLICE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADR,
    ST_DATA
  } rd_state_e;
endpackage

// File: rtl/rom_cfg_sense.sv
module rom_cfg_sense #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BASE_LOG2 = 14,
  parameter int unsigned SENSE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        strap_i,
  output logic              cfg_valid_o,
  output logic [1:0]        wait_sel_o,
  output logic              three_lat_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int unsigned CODE_MAX = ADDR_W - BASE_LOG2;
  localparam int unsigned CNT_W    = $clog2(SENSE_CYC + 1);
  localparam int unsigned TWO_LOG2 = 2 * rom_bus_pkg::SLICE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic [2:0]       code_q;
  logic [1:0]       wsel_q;
  logic [2:0]       code_in;

  assign code_in = (strap_i[2:0] > 3'(CODE_MAX)) ? 3'(CODE_MAX) : strap_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      code_q  <= '0;
      wsel_q  <= '0;
    end else if (!valid_q) begin
      if (cnt_q == CNT_W'(SENSE_CYC - 1)) begin
        valid_q <= 1'b1;
        code_q  <= code_in;
        wsel_q  <= strap_i[4:3];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cfg_valid_o = valid_q;
  assign wait_sel_o  = wsel_q;
  assign three_lat_o = (BASE_LOG2 + 32'(code_q)) > TWO_LOG2;
  assign mask_o      = ~({ADDR_W{1'b1}} << (BASE_LOG2 + 32'(code_q)));
endmodule

// File: rtl/rom_addr_slice.sv
module rom_addr_slice #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned NUM_LAT = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        idx_i,
  output logic [7:0]        byte_o
);
  localparam int unsigned EXT_W = 8 * NUM_LAT;

  logic [EXT_W-1:0] addr_ext;
  logic [7:0]       slices [NUM_LAT];

  assign addr_ext = EXT_W'(addr_i);

  for (genvar k = 0; k < NUM_LAT; k++) begin : g_slice
    assign slices[k] = addr_ext[8*k +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NUM_LAT; k++) begin
      if (idx_i == 2'(k)) byte_o = slices[k];
    end
  end
endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_bus_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned NUM_LAT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic               three_lat_i,
  input  logic [1:0]         wait_sel_i,
  input  logic [ADDR_W-1:0]  mask_i,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         bus_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [1:0]         idx_o,
  output logic [NUM_LAT-1:0] latch_o,
  output logic               bus_oe_o,
  output logic               rom_oe_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [7:0]         data_o
);
  rd_state_e         st_q;
  logic [1:0]        idx_q;
  logic [3:0]        wcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              done_q;
  logic [3:0]        wlast;
  logic [1:0]        idx_last;

  assign wlast    = 4'((5'd1 << wait_sel_i) - 5'd1);
  assign idx_last = three_lat_i ? 2'd2 : 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      wcnt_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i && cfg_valid_i) begin
            addr_q <= addr_i & mask_i;
            idx_q  <= '0;
            st_q   <= ST_ADR;
          end
        end
        ST_ADR: begin
          if (idx_q == idx_last) begin
            wcnt_q <= '0;
            st_q   <= ST_DATA;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (wcnt_q == wlast) begin
            data_q <= bus_i;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign idx_o    = idx_q;
  assign bus_oe_o = (st_q == ST_ADR);
  assign rom_oe_o = (st_q == ST_DATA);
  assign latch_o  = bus_oe_o ? (NUM_LAT'(1) << idx_q) : '0;
  assign busy_o   = !cfg_valid_i || (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign data_o   = data_q;
endmodule

// File: rtl/rom_bus_if.sv
module rom_bus_if #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BASE_LOG2 = 14,
  parameter int unsigned SENSE_CYC = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [7:0]                 data_o,
  input  logic [7:0]                 bus_i,
  output logic [7:0]                 bus_o,
  output logic                       bus_oe_o,
  output logic [((ADDR_W+7)/8)-1:0]  latch_o,
  output logic                       rom_oe_o,
  output logic                       cfg_valid_o,
  output logic [ADDR_W-1:0]          rom_mask_o
);
  localparam int unsigned NUM_LAT = (ADDR_W + 7) / 8;

  logic              three_lat;
  logic [1:0]        wait_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        idx;
  logic [7:0]        slice;

  rom_cfg_sense #(
    .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2), .SENSE_CYC(SENSE_CYC)
  ) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (bus_i[4:0]),
    .cfg_valid_o(cfg_valid_o),
    .wait_sel_o (wait_sel),
    .three_lat_o(three_lat),
    .mask_o     (rom_mask_o)
  );

  rom_rd_seq #(.ADDR_W(ADDR_W), .NUM_LAT(NUM_LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_valid_i(cfg_valid_o),
    .three_lat_i(three_lat),
    .wait_sel_i (wait_sel),
    .mask_i     (rom_mask_o),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .bus_i      (bus_i),
    .addr_o     (addr_q),
    .idx_o      (idx),
    .latch_o    (latch_o),
    .bus_oe_o   (bus_oe_o),
    .rom_oe_o   (rom_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .data_o     (data_o)
  );

  rom_addr_slice #(.ADDR_W(ADDR_W), .NUM_LAT(NUM_LAT)) u_slice (
    .addr_i(addr_q),
    .idx_i (idx),
    .byte_o(slice)
  );

  assign bus_o = bus_oe_o ? slice : 8'h00;
endmodule

// File: rtl/rom_bus_if_chk.sv
module rom_bus_if_chk #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned NUM_LAT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               done_o,
  input logic               bus_oe_o,
  input logic [NUM_LAT-1:0] latch_o,
  input logic               rom_oe_o,
  input logic               cfg_valid_o,
  input logic [ADDR_W-1:0]  rom_mask_o
);
  logic [ADDR_W:0] size_v;
  assign size_v = {1'b0, rom_mask_o} + 1'b1;

  p_undriven_sense_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_o |-> (!bus_oe_o && !rom_oe_o && latch_o == '0));

  p_cfg_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> (cfg_valid_o && $stable(rom_mask_o)));

  p_mask_pow2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> ($countones(size_v) == 1 && rom_mask_o[13:0] == 14'h3fff));

  p_strobe_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(latch_o) && (latch_o != '0 || !bus_oe_o));

  p_strobe_order1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o[1] |-> $past(latch_o[0]));

  p_strobe_order2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o[2] |-> $past(latch_o[1]));

  p_drive_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_oe_o && rom_oe_o));

  p_done_after_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(rom_oe_o) && !rom_oe_o));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_oe_o && !rom_oe_o));
endmodule

bind rom_bus_if rom_bus_if_chk #(.ADDR_W(ADDR_W), .NUM_LAT((ADDR_W + 7) / 8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bus_oe_o   (bus_oe_o),
  .latch_o    (latch_o),
  .rom_oe_o   (rom_oe_o),
  .cfg_valid_o(cfg_valid_o),
  .rom_mask_o (rom_mask_o)
);

// File: tb/tb_rom_bus_if.sv
module tb_rom_bus_if;
  localparam int ADDR_W    = 20;
  localparam int BASE_LOG2 = 14;
  localparam int SENSE_CYC = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              busy_o, done_o, bus_oe_o, rom_oe_o, cfg_valid_o;
  logic [7:0]        data_o, bus_o, bus_i;
  logic [2:0]        latch_o;
  logic [ADDR_W-1:0] rom_mask_o;
  logic [7:0]        sense_pat = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  int cur_size = 16384;
  int cur_wait = 1;

  always #2 clk = ~clk;

  rom_bus_if #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2), .SENSE_CYC(SENSE_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .latch_o(latch_o),
    .rom_oe_o(rom_oe_o), .cfg_valid_o(cfg_valid_o), .rom_mask_o(rom_mask_o)
  );

  // external holding registers and ROM
  logic [7:0] hold0 = '0, hold1 = '0, hold2 = '0;
  always @(posedge clk) begin
    if (latch_o[0]) hold0 <= bus_o;
    if (latch_o[1]) hold1 <= bus_o;
    if (latch_o[2]) hold2 <= bus_o;
  end

  function automatic logic [7:0] rom_byte(int a);
    return 8'((a * 7) ^ (a >> 8) ^ (a >> 13) ^ 8'h5a);
  endfunction

  int rom_a;
  assign rom_a = int'({hold2, hold1, hold0}) & (cur_size - 1);
  assign bus_i = rom_oe_o ? rom_byte(rom_a) : sense_pat;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [2:0] latch;
    logic       oe;
    logic [7:0] bval;
    logic       roe;
    logic       done;
    logic [7:0] data;
    logic       busy;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] exp_data = '0;

  always @(negedge clk) begin : cmp
    exp_t e;
    if (cmp_en) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = '{3'b000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0};
      if (e.done) exp_data = e.data;
      chk("R5 latch strobes", int'(latch_o), int'(e.latch));
      chk("R5 bus driver enable", int'(bus_oe_o), int'(e.oe));
      if (e.oe) chk("R5 address slice", int'(bus_o), int'(e.bval));
      chk("R6 rom output enable", int'(rom_oe_o), int'(e.roe));
      chk("R6 done pulse", int'(done_o), int'(e.done));
      if (e.done) chk("R7 read data", int'(data_o), int'(exp_data));
      else chk("R9 data held", int'(data_o), int'(exp_data));
      chk("R8 busy", int'(busy_o), int'(e.busy));
    end
  end

  task automatic push_read(int addr);
    int ea = addr & (cur_size - 1);
    exp_q.push_back('{3'b001, 1'b1, 8'(ea), 1'b0, 1'b0, 8'h00, 1'b1});
    exp_q.push_back('{3'b010, 1'b1, 8'(ea >> 8), 1'b0, 1'b0, 8'h00, 1'b1});
    if (cur_size > 65536)
      exp_q.push_back('{3'b100, 1'b1, 8'(ea >> 16), 1'b0, 1'b0, 8'h00, 1'b1});
    for (int i = 0; i < cur_wait; i++)
      exp_q.push_back('{3'b000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1});
    exp_q.push_back('{3'b000, 1'b0, 8'h00, 1'b0, 1'b1, rom_byte(ea), 1'b0});
  endtask

  task automatic do_read(int addr, bit poke);
    @(negedge clk); #1;
    req_i = 1'b1;
    addr_i = ADDR_W'(addr);
    push_read(addr);
    @(negedge clk); #1;
    req_i = 1'b0;
    if (poke) begin // R8: request while busy must be dropped
      req_i = 1'b1;
      addr_i = ~ADDR_W'(addr);
      @(negedge clk); #1;
      req_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic reset_sense(logic [7:0] pat);
    int code;
    cmp_en = 0;
    exp_q.delete();
    @(negedge clk);
    rst_ni = 1'b0;
    req_i = 1'b0;
    sense_pat = pat;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 1);
    chk("R1 cfg_valid in reset", int'(cfg_valid_o), 0);
    chk("R1 bus_oe in reset", int'(bus_oe_o), 0);
    chk("R1 rom_oe in reset", int'(rom_oe_o), 0);
    chk("R1 latch in reset", int'(latch_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 data in reset", int'(data_o), 0);
    exp_data = '0;
    code = int'(pat[2:0]);
    if (code > ADDR_W - BASE_LOG2) code = ADDR_W - BASE_LOG2;
    cur_size = 1 << (BASE_LOG2 + code);
    cur_wait = 1 << int'(pat[4:3]);
    #1;
    rst_ni = 1'b1;
    req_i = 1'b1; // R8: must be ignored before configuration
    for (int i = 1; i <= SENSE_CYC; i++) begin
      @(negedge clk);
      if (i < SENSE_CYC) begin
        chk("R2 cfg_valid before sample", int'(cfg_valid_o), 0);
        chk("R2 bus undriven while sensing", int'(bus_oe_o), 0);
        chk("R8 no strobe before config", int'(latch_o), 0);
      end else begin
        chk("R2 cfg_valid at sample", int'(cfg_valid_o), 1);
        chk("R3 size mask", int'(rom_mask_o), cur_size - 1);
      end
    end
    #1;
    req_i = 1'b0;
    sense_pat = ~pat; // R2: later bus values must not reconfigure
    cmp_en = 1;
  endtask

  task automatic run_cfg(logic [7:0] pat);
    reset_sense(pat);
    do_read(0, 0);
    do_read(32'h12345, 1);
    do_read(cur_size - 1, 0);
    do_read(cur_size + 5, 0);          // R7 wrap
    do_read(32'hFFFFF, 1);
    do_read(32'hA5A5A, 0);
    repeat (3) @(negedge clk);
    chk("R2 mask unchanged after bus activity", int'(rom_mask_o), cur_size - 1);
    chk("R4 ready after reads", int'(busy_o), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    run_cfg(8'b000_00_000);  // 16 KB, 1 wait
    run_cfg(8'b111_01_010);  // 64 KB, 2 waits, upper bits ignored
    run_cfg(8'b000_11_011);  // 128 KB, 8 waits, three strobes
    run_cfg(8'b000_10_111);  // clamped 1 MB, 4 waits
    run_cfg(8'b010_00_110);  // 1 MB, 1 wait
    cmp_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule